// File: doc/BRIEF.md
# Software-Clocked Serial Shift Port

This block is a minimal three-wire synchronous serial port. It has a data input, a data output and a serial clock. An 8-bit shift register and a 4-bit edge counter advance together on one clock source. Software picks that source from three choices:

- the external clock pin, after synchronisation;
- a timer compare-match pulse;
- a software strobe written over the register bus.

The block has no slave-select logic. Transfers follow SPI modes 0 and 1, and a mode bit chooses which clock edge samples the input.

In the master role, software produces the clock. Each strobe or timer pulse toggles the clock output and counts as one edge. In the slave role, the block follows the external clock pin and counts both of its edges. A full byte is therefore 16 counts. When the counter wraps from 15 to 0, it sets a sticky overflow flag, which can also drive an interrupt line. Software preloads the counter, for example to 0, so that the flag marks the end of the transfer.

Top module: `ssi_port`

## Requirements
- R1: After reset, the data register, counter, overflow flag, control fields, clock output, data output and interrupt are all 0.
- R2: The data output always equals bit 7 of the data register. Data shifts MSB first.
- R3: On a sample edge, the data input is captured into a one-bit latch, and the data register does not change. On the opposite (shift) edge, the data register moves left by one and the latched bit enters bit 0. With mode bit 0 (control bit 2), rising edges sample and falling edges shift. With mode bit 1, the roles swap.
- R4: Each edge from the selected source adds one to the 4-bit counter (address 1, bits 3:0). A bus write to the counter in the same cycle takes priority.
- R5: With source code 0 (external pin), both edges of the clock pin count. A level change takes effect on the third rising system-clock edge after it appears.
- R6: Writing 1 to control bit 5 (address 2) toggles the clock output. With source code 2 (software), that write also counts as an edge. Its direction is the new clock-output level.
- R7: With source code 1 (timer), a compare-match pulse toggles the clock output and counts as an edge. With any other source, the pulse changes nothing.
- R8: A counter step from 15 to 0 sets the overflow flag (control bit 4). The interrupt output is high whenever both the flag and the enable (control bit 3) are set.
- R9: Writing 1 to control bit 4 clears the flag. If a wrap happens in the same cycle, the flag stays set.
- R10: A bus write to the data register (address 0) replaces its contents and takes priority over a shift in the same cycle.
- R11: Edges on the clock pin do not change the data register or the counter while another source is selected.
- R12: When two ports are cross-connected and the master issues 16 strobes, the two data registers exchange their contents and both flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 data, 1 counter, 2 control/status |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for bus_addr (combinational) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sck_in | input | 1 | External serial clock pin (asynchronous) |
| sck_out | output | 1 | Clock output driven by strobes and timer pulses |
| tmr_match | input | 1 | Timer compare-match pulse, one cycle wide |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
On every cycle, the assertions check several local rules:

- the counter steps by exactly one on each selected edge;
- a shift moves the register left by one;
- a sample edge leaves the output bit steady;
- the flag rises only from count 15, and a clear without a wrap drops it;
- each strobe flips the clock output.

Other behaviour can only be shown by the bench's scenarios and its per-cycle reference model. This covers the three-cycle synchroniser delay, the choice of source, the write-over-shift priority, and the full byte exchange between a master and a slave port.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef enum logic [1:0] {
    SRC_PIN = 2'd0,
    SRC_TMR = 2'd1,
    SRC_SW  = 2'd2,
    SRC_OFF = 2'd3
  } clk_src_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  localparam int B_MODE   = 2;
  localparam int B_IE     = 3;
  localparam int B_FLAG   = 4;
  localparam int B_STROBE = 5;
endpackage

// File: rtl/ssi_edge_sel.sv
module ssi_edge_sel
  import ssi_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sck_pin,
  input  clk_src_e src,
  input  logic     tmr_pulse,
  input  logic     sw_strobe,
  input  logic     sck_level,
  output logic     edge_evt,
  output logic     edge_rise,
  output logic     tog_req
);
  localparam int PW = SYNC + 1;

  logic [PW-1:0] pipe;
  logic          pin_lvl, pin_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[PW-2:0], sck_pin};
  end

  assign pin_lvl  = pipe[SYNC-1];
  assign pin_prev = pipe[SYNC];
  assign tog_req  = sw_strobe | ((src == SRC_TMR) & tmr_pulse);

  always_comb begin
    edge_evt  = 1'b0;
    edge_rise = 1'b0;
    case (src)
      SRC_PIN: begin
        edge_evt  = pin_lvl ^ pin_prev;
        edge_rise = pin_lvl;
      end
      SRC_TMR: begin
        edge_evt  = tmr_pulse;
        edge_rise = ~sck_level;
      end
      SRC_SW: begin
        edge_evt  = sw_strobe;
        edge_rise = ~sck_level;
      end
      default: begin
        edge_evt  = 1'b0;
        edge_rise = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ssi_shift.sv
module ssi_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          sample_evt,
  input  logic          shift_evt,
  input  logic          sdi,
  output logic [DW-1:0] q
);
  logic smp;

  function automatic logic [DW-1:0] push_lsb(input logic [DW-1:0] v, input logic b);
    return {v[DW-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      smp <= 1'b0;
    end else begin
      if (sample_evt) smp <= sdi;
      if (wr)             q <= wdata;
      else if (shift_evt) q <= push_lsb(q, smp);
    end
  end
endmodule

// File: rtl/ssi_count.sv
module ssi_count #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          step,
  input  logic          clr_req,
  output logic [CW-1:0] cnt,
  output logic          flag,
  output logic          wrap_evt
);
  function automatic logic [CW:0] bump(input logic [CW-1:0] v);
    return {1'b0, v} + {{CW{1'b0}}, 1'b1};
  endfunction

  logic [CW:0] nxt;

  assign nxt      = bump(cnt);
  assign wrap_evt = step & ~wr & nxt[CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (wr)        cnt <= wdata;
      else if (step) cnt <= nxt[CW-1:0];
      if (wrap_evt)     flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ssi_port.sv
module ssi_port
  import ssi_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 4,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sdi,
  output logic          sdo,
  input  logic          sck_in,
  output logic          sck_out,
  input  logic          tmr_match,
  output logic          ovf_irq
);
  localparam int PAD = DW - CW;

  clk_src_e      src_q;
  logic          mode_q, ie_q, sck_q;
  logic          wr_data, wr_cnt, wr_ctrl, sw_strobe, clr_req;
  logic          edge_evt, edge_rise, tog_req;
  logic          sample_evt, shift_evt, wrap_evt;
  logic [DW-1:0] data_q, ctrl_rd;
  logic [CW-1:0] cnt_q;
  logic          flag_q;

  assign wr_data   = bus_wr & (bus_addr == A_DATA);
  assign wr_cnt    = bus_wr & (bus_addr == A_CNT);
  assign wr_ctrl   = bus_wr & (bus_addr == A_CTRL);
  assign sw_strobe = wr_ctrl & bus_wdata[B_STROBE];
  assign clr_req   = wr_ctrl & bus_wdata[B_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_PIN;
      mode_q <= 1'b0;
      ie_q   <= 1'b0;
      sck_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        src_q  <= clk_src_e'(bus_wdata[1:0]);
        mode_q <= bus_wdata[B_MODE];
        ie_q   <= bus_wdata[B_IE];
      end
      if (tog_req) sck_q <= ~sck_q;
    end
  end

  ssi_edge_sel #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .sck_pin(sck_in), .src(src_q),
    .tmr_pulse(tmr_match), .sw_strobe(sw_strobe), .sck_level(sck_q),
    .edge_evt(edge_evt), .edge_rise(edge_rise), .tog_req(tog_req)
  );

  assign sample_evt = edge_evt & (edge_rise ^ mode_q);
  assign shift_evt  = edge_evt & ~(edge_rise ^ mode_q);

  ssi_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .wr(wr_data), .wdata(bus_wdata),
    .sample_evt(sample_evt), .shift_evt(shift_evt), .sdi(sdi), .q(data_q)
  );

  ssi_count #(.CW(CW)) u_count (
    .clk(clk), .rst_n(rst_n), .wr(wr_cnt), .wdata(bus_wdata[CW-1:0]),
    .step(edge_evt), .clr_req(clr_req),
    .cnt(cnt_q), .flag(flag_q), .wrap_evt(wrap_evt)
  );

  always_comb begin
    ctrl_rd         = '0;
    ctrl_rd[1:0]    = src_q;
    ctrl_rd[B_MODE] = mode_q;
    ctrl_rd[B_IE]   = ie_q;
    ctrl_rd[B_FLAG] = flag_q;
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = data_q;
      A_CNT:   bus_rdata = {{PAD{1'b0}}, cnt_q};
      A_CTRL:  bus_rdata = ctrl_rd;
      default: bus_rdata = '0;
    endcase
  end

  assign sdo     = data_q[DW-1];
  assign sck_out = sck_q;
  assign ovf_irq = flag_q & ie_q;
endmodule

// File: rtl/ssi_port_chk.sv
module ssi_port_chk #(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sdo,
  input logic          sck_out,
  input logic          edge_evt,
  input logic          sample_evt,
  input logic          shift_evt,
  input logic          wrap_evt,
  input logic          wr_data,
  input logic          wr_cnt,
  input logic          clr_req,
  input logic          sw_strobe,
  input logic [DW-1:0] data_q,
  input logic [CW-1:0] cnt_q,
  input logic          flag_q
);
  AST_ONE_EDGE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_evt && shift_evt)); // R3
  AST_SAMPLE_HOLDS_DO: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt && !wr_data |=> $stable(sdo)); // R3
  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt && !wr_data |=> data_q[DW-1:1] == $past(data_q[DW-2:0])); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt && !wr_cnt |=> cnt_q == CW'($past(cnt_q) + 1'b1)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_evt && !wr_data |=> $stable(data_q)); // R11
  AST_STROBE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    sw_strobe |=> sck_out != $past(sck_out)); // R6
  AST_FLAG_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cnt_q) == {CW{1'b1}}); // R8
  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flag_q); // R8
  AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req && !wrap_evt |=> !flag_q); // R9
endmodule

bind ssi_port ssi_port_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .sck_out(sck_out),
  .edge_evt(edge_evt), .sample_evt(sample_evt), .shift_evt(shift_evt),
  .wrap_evt(wrap_evt), .wr_data(wr_data), .wr_cnt(wr_cnt),
  .clr_req(clr_req), .sw_strobe(sw_strobe),
  .data_q(data_q), .cnt_q(cnt_q), .flag_q(flag_q)
);

// File: tb/test_ssi_port.sv
module test_ssi_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] m_addr = 2'd0, p_addr = 2'd0;
  logic       m_wr = 1'b0, p_wr = 1'b0;
  logic [7:0] m_wd = 8'd0, p_wd = 8'd0;
  logic [7:0] m_rd, p_rd;
  logic       m_sdo, p_sdo, m_sck, p_sck, m_irq, p_irq;
  logic       ext_sck = 1'b0, ext_sdi = 1'b0, sel_peer = 1'b0, tmr = 1'b0;
  logic       m_sdi;

  assign m_sdi = sel_peer ? p_sdo : ext_sdi;

  ssi_port i_ssi_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(m_addr), .bus_wr(m_wr), .bus_wdata(m_wd),
    .bus_rdata(m_rd), .sdi(m_sdi), .sdo(m_sdo), .sck_in(ext_sck),
    .sck_out(m_sck), .tmr_match(tmr), .ovf_irq(m_irq)
  );

  ssi_port i_peer (
    .clk(clk), .rst_n(rst_n), .bus_addr(p_addr), .bus_wr(p_wr), .bus_wdata(p_wd),
    .bus_rdata(p_rd), .sdi(m_sdo), .sdo(p_sdo), .sck_in(m_sck),
    .sck_out(p_sck), .tmr_match(1'b0), .ovf_irq(p_irq)
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference of the main port
  int m_data, m_cnt, m_flag, m_src, m_mode, m_ie, m_sckm, m_smp;
  int pin_hist[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data = 0; m_cnt = 0; m_flag = 0; m_src = 0; m_mode = 0;
      m_ie = 0; m_sckm = 0; m_smp = 0;
      pin_hist = '{0, 0, 0};
    end else begin
      bit ev, lvl, strobe, tp, wrap;
      ev = 0; lvl = 0; wrap = 0;
      strobe = m_wr && m_addr == 2 && m_wd[5];
      tp = tmr && m_src == 1;
      if (m_src == 0 && pin_hist[1] != pin_hist[2]) begin ev = 1; lvl = pin_hist[1][0]; end
      if (m_src == 2 && strobe) begin ev = 1; lvl = !m_sckm; end
      if (tp) begin ev = 1; lvl = !m_sckm; end
      if (ev && (lvl != m_mode[0])) m_smp = m_sdi;
      if (m_wr && m_addr == 0) m_data = m_wd;
      else if (ev && (lvl == m_mode[0])) m_data = ((m_data * 2) + m_smp_prev) % 256;
      if (m_wr && m_addr == 1) m_cnt = m_wd % 16;
      else if (ev) begin wrap = (m_cnt == 15); m_cnt = (m_cnt + 1) % 16; end
      if (wrap) m_flag = 1;
      else if (m_wr && m_addr == 2 && m_wd[4]) m_flag = 0;
      if (m_wr && m_addr == 2) begin
        m_src = m_wd[1:0]; m_mode = m_wd[2]; m_ie = m_wd[3];
      end
      if (strobe || tp) m_sckm = !m_sckm;
      pin_hist.push_front(int'(ext_sck));
      void'(pin_hist.pop_back());
    end
    m_smp_prev = m_smp;
  end
  int m_smp_prev = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int exp_rd;
      case (m_addr)
        2'd0: exp_rd = m_data;
        2'd1: exp_rd = m_cnt;
        2'd2: exp_rd = m_src + m_mode * 4 + m_ie * 8 + m_flag * 16;
        default: exp_rd = 0;
      endcase
      chk(m_addr == 0 ? "R3 data" : m_addr == 1 ? "R4 count" : "R9 ctrl", m_rd, exp_rd);
      chk("R2 sdo", m_sdo, (m_data >> 7) & 1);
      chk("R6 sck_out", m_sck, m_sckm);
      chk("R8 irq", m_irq, m_flag & m_ie);
    end
  end

  task automatic mwr(input logic [1:0] a, input logic [7:0] d, input logic pulse);
    @(posedge clk); #2;
    m_addr = a; m_wr = 1'b1; m_wd = d; tmr = pulse;
    @(posedge clk); #2;
    m_wr = 1'b0; tmr = 1'b0;
  endtask

  task automatic pwr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2;
    p_addr = a; p_wr = 1'b1; p_wd = d;
    @(posedge clk); #2;
    p_wr = 1'b0;
  endtask

  task automatic rchk(input string tag, input logic [1:0] a, input int exp);
    @(posedge clk); #2;
    m_addr = a;
    @(negedge clk);
    chk(tag, m_rd, exp);
  endtask

  task automatic pulse;
    @(posedge clk); #2; tmr = 1'b1;
    @(posedge clk); #2; tmr = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    rchk("R1 data", 0, 0);
    rchk("R1 count", 1, 0);
    rchk("R1 ctrl", 2, 0);
    chk("R1 sdo", m_sdo, 0); chk("R1 sck", m_sck, 0); chk("R1 irq", m_irq, 0);

    // R12 byte exchange, master software strobes, slave follows pin
    sel_peer = 1'b1;
    mwr(2, 8'h02, 0);
    mwr(0, 8'hA5, 0);
    mwr(1, 8'h00, 0);
    pwr(0, 8'h3C);
    for (int i = 0; i < 16; i++) begin
      mwr(2, 8'h22, 0);
      repeat (6) @(posedge clk);
    end
    rchk("R12 master data", 0, 8'h3C);
    @(posedge clk); #2; p_addr = 0;
    @(negedge clk); chk("R12 peer data", p_rd, 8'hA5);
    @(posedge clk); #2; p_addr = 2;
    @(negedge clk); chk("R12 peer flag", (p_rd >> 4) & 1, 1);
    rchk("R12 master count", 1, 0);
    rchk("R8 flag after wrap", 2, 8'h12);
    chk("R6 sck back low", m_sck, 0);
    sel_peer = 1'b0;

    // R9 clear flag, then R11: pin edges ignored under software source
    mwr(2, 8'h12, 0);
    rchk("R9 flag cleared", 2, 8'h02);
    rchk("R11 data before", 0, 8'h3C);
    m_addr = 1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2; ext_sck = ~ext_sck;
      repeat (4) @(posedge clk);
    end
    pulse();
    rchk("R11 count held", 1, 0);
    rchk("R11 data held", 0, 8'h3C);
    chk("R7 sck ignores timer", m_sck, 0);

    // R5 external pin, mode 1, latency and both edges
    ext_sdi = 1'b1;
    mwr(2, 8'h04, 0);
    mwr(0, 8'h00, 0);
    mwr(1, 8'h00, 0);
    @(posedge clk); #2; m_addr = 1; ext_sck = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R5 not yet counted", m_rd, 0);
    @(negedge clk);
    chk("R5 counted on third edge", m_rd, 1);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #2; ext_sck = ~ext_sck;
      repeat (4) @(posedge clk);
    end
    rchk("R5 four edges", 1, 4);
    @(posedge clk); #2; m_addr = 0;
    @(negedge clk); chk("R3 bit0 from sdi", m_rd & 1, 1);

    // R7 timer source
    mwr(2, 8'h01, 0);
    mwr(1, 8'h00, 0);
    pulse(); pulse(); pulse();
    rchk("R7 three pulses", 1, 3);
    chk("R7 sck toggled", m_sck, 1);

    // R10 / R4 write priority over concurrent edge
    mwr(0, 8'h5A, 1);
    rchk("R10 write beats shift", 0, 8'h5A);
    mwr(1, 8'h09, 1);
    rchk("R4 write beats step", 1, 9);

    // R8 wrap with interrupt enable
    mwr(2, 8'h09, 0);
    mwr(1, 8'h0F, 0);
    pulse();
    rchk("R8 wrapped count", 1, 0);
    rchk("R8 flag set", 2, 8'h19);
    chk("R8 irq high", m_irq, 1);

    // R9 set wins over clear
    mwr(1, 8'h0F, 0);
    mwr(2, 8'h19, 1);
    rchk("R9 set beats clear", 2, 8'h19);
    mwr(2, 8'h19, 0);
    rchk("R9 cleared", 2, 8'h09);
    chk("R9 irq low", m_irq, 0);

    repeat (4) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule